// File: doc/BRIEF.md
# Transmit Command-Word Packet Parser

This block accepts 32-bit words that a host writes into a transmit data port and interprets them as a sequence of packet buffers. Every buffer begins with two control words. The first control word gives the payload byte count, a start offset in bytes, an end-alignment code, first-segment and last-segment marks, and a completion-request bit. The second control word carries a packet tag in its upper half. The data words that follow hold any leading offset bytes, then the payload, then padding that rounds the buffer up to its alignment.

Incoming words are held in a small word FIFO. The parser takes the payload bytes from each data word in little-endian order and sends them out on a byte stream with valid, first and last marks. When a buffer flagged as a last segment finishes, the upper half of its second control word is stored as a status entry in a 512-entry status FIFO. The host can read that FIFO in show-ahead fashion. Single-cycle pulses report three events: completion requests, the status FIFO becoming full, and words dropped because the word FIFO was full.

Top module: `txp_top`

## Requirements
- R1: After reset, `byte_vld`, `ioc_pulse`, `stat_full_pulse` and `overrun_pulse` are low and `stat_count` is 0.
- R2: Control word one carries the payload byte count in bits 10:0. The payload bytes of each data word are sent lowest byte first (bits 7:0, then 15:8, 23:16, 31:24), one byte per `byte_vld` cycle.
- R3: Control word one carries the start offset in bits 20:16. That many leading bytes of the data area, including whole words, are consumed and never sent.
- R4: Control word one bits 25:24 select the end alignment: 0 or 3 pads the data area (offset plus count) to 4 bytes, 1 to 16 bytes and 2 to 32 bytes. Pad words are consumed, and the word after them is parsed as a new control word one.
- R5: `byte_first` is high only on the first payload byte after a buffer with bit 13 (first segment) set. `byte_last` is high only on the final payload byte of a buffer with bit 12 (last segment) set.
- R6: A status entry is stored only when a last-segment buffer completes. Its value is control word two bits 31:16 placed in bits 31:16 of `stat_data`, with bits 15:0 zero. Entries leave in arrival order.
- R7: `ioc_pulse` is high for one cycle when a buffer whose control word one has bit 31 set completes, and at no other time.
- R8: The status FIFO holds at most 512 entries. A completion that finds it full stores nothing. `stat_full_pulse` fires once, on the entry that fills it.
- R9: A word written while the word FIFO is full is discarded, and `overrun_pulse` is high for one cycle.
- R10: `stat_pop` while `stat_count` is 0 has no effect, and the count stays 0.
- R11: Bits of control word one outside the mask 0x831F37FF (for example bits 11 and 14) have no effect on parsing.
- R12: A buffer whose byte count and offset are both 0 takes no data words and completes as soon as control word two is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Host writes a word this cycle |
| wr_data | input | 32 | Word written by the host |
| stat_pop | input | 1 | Remove the head status entry |
| byte_vld | output | 1 | Payload byte valid |
| byte_dat | output | 8 | Payload byte |
| byte_first | output | 1 | First byte of a packet |
| byte_last | output | 1 | Final byte of a packet |
| stat_data | output | 32 | Head status entry (tag in 31:16) |
| stat_count | output | 10 | Number of stored status entries |
| ioc_pulse | output | 1 | Completion request pulse |
| stat_full_pulse | output | 1 | Status FIFO became full |
| overrun_pulse | output | 1 | Word discarded, word FIFO full |

## Verification
The hardest state to reach is a full status FIFO, because it takes 512 completed last-segment buffers. The stimulus uses zero-length buffers, which finish in the command phase, so each packet costs only two writes and the word FIFO can drain at the full write rate. The second hard case is word FIFO overrun. Each data word needs several cycles to unpack, so a back-to-back burst of 40 data words overflows the 16-word FIFO. The bench then counts the dropped words and refills exactly that many, so the stalled buffer can finish.

// File: rtl/txp_pkg.sv
package txp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMDB = 2'd1,
    ST_DATA = 2'd2
  } pstate_t;

  localparam logic [31:0] CMDA_MASK = 32'h831F_37FF;
  localparam int CNT_LSB   = 0;
  localparam int CNT_W     = 11;
  localparam int OFF_LSB   = 16;
  localparam int OFF_W     = 5;
  localparam int ALN_LSB   = 24;
  localparam int LAST_BIT  = 12;
  localparam int FIRST_BIT = 13;
  localparam int IOC_BIT   = 31;

  // words consumed by the data area after end alignment
  function automatic logic [11:0] pad_words(input logic [10:0] cnt,
                                            input logic [4:0]  off,
                                            input logic [1:0]  code);
    logic [12:0] sum;
    logic [11:0] w;
    sum = {2'b00, cnt} + {8'd0, off} + 13'd3;
    w   = {1'b0, sum[12:2]};
    case (code)
      2'd1:    pad_words = (w + 12'd3) & ~12'd3;
      2'd2:    pad_words = (w + 12'd7) & ~12'd7;
      default: pad_words = w;
    endcase
  endfunction

endpackage

// File: rtl/txp_word_fifo.sv
module txp_word_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             ovr_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_d, ovr_q;
  logic          do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_data = mem[rp_q];
  assign ovr_pulse = ovr_q;

  always_comb begin
    do_wr = wr_en && !full;
    do_rd = rd_en && !empty;
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (do_wr) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + CW'(do_wr) - CW'(do_rd);
    ovr_d = wr_en && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/txp_stat_fifo.sv
module txp_stat_fifo #(
  parameter int DEPTH = 512,
  parameter int TAG_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [TAG_W-1:0]            tag,
  input  logic                        pop,
  output logic [TAG_W-1:0]            head_tag,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        full_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_d, full_q;
  logic          do_wr, do_rd;

  assign head_tag   = mem[rp_q];
  assign count      = cnt_q;
  assign full_pulse = full_q;

  always_comb begin
    do_wr  = push && (cnt_q != CW'(DEPTH));
    do_rd  = pop && (cnt_q != '0);
    wp_d   = wp_q;
    rp_d   = rp_q;
    if (do_wr) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d  = cnt_q + CW'(do_wr) - CW'(do_rd);
    full_d = do_wr && !do_rd && (cnt_q == CW'(DEPTH - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= tag;
  end
endmodule

// File: rtl/txp_parser.sv
module txp_parser
  import txp_pkg::*;
#(
  parameter int WCNT_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wf_empty,
  input  logic [31:0] wf_data,
  output logic        wf_pop,
  output logic        byte_vld,
  output logic [7:0]  byte_dat,
  output logic        byte_first,
  output logic        byte_last,
  output logic        st_push,
  output logic [15:0] st_tag,
  output logic        ioc_pulse
);
  localparam int G_W = WCNT_W + 2;

  pstate_t           state_q, state_d;
  logic [31:0]       cmda_q, cmda_d;
  logic [15:0]       tag_q, tag_d;
  logic [WCNT_W-1:0] total_q, total_d;
  logic [WCNT_W-1:0] widx_q, widx_d;
  logic [1:0]        lane_q, lane_d;
  logic              have_q, have_d;
  logic [31:0]       cur_q, cur_d;
  logic              pstart_q, pstart_d;
  logic              bv_q, bv_d, bf_q, bf_d, bl_q, bl_d, ioc_q, ioc_d;
  logic [7:0]        bd_q, bd_d;
  logic              fin;

  logic [CNT_W-1:0]  f_cnt;
  logic [OFF_W-1:0]  f_off;
  logic [G_W-1:0]    gidx, g_end;
  logic              pay;

  assign f_cnt = cmda_q[CNT_LSB +: CNT_W];
  assign f_off = cmda_q[OFF_LSB +: OFF_W];
  assign gidx  = {widx_q, lane_q};
  assign g_end = G_W'(f_off) + G_W'(f_cnt);
  assign pay   = (gidx >= G_W'(f_off)) && (gidx < g_end);

  always_comb begin
    state_d  = state_q;
    cmda_d   = cmda_q;
    tag_d    = tag_q;
    total_d  = total_q;
    widx_d   = widx_q;
    lane_d   = lane_q;
    have_d   = have_q;
    cur_d    = cur_q;
    pstart_d = pstart_q;
    bv_d     = 1'b0;
    bd_d     = bd_q;
    bf_d     = 1'b0;
    bl_d     = 1'b0;
    wf_pop   = 1'b0;
    fin      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!wf_empty) begin
          wf_pop  = 1'b1;
          cmda_d  = wf_data & CMDA_MASK;
          if (wf_data[FIRST_BIT]) pstart_d = 1'b1;
          state_d = ST_CMDB;
        end
      end
      ST_CMDB: begin
        if (!wf_empty) begin
          wf_pop  = 1'b1;
          tag_d   = wf_data[31:16];
          total_d = WCNT_W'(pad_words(f_cnt, f_off, cmda_q[ALN_LSB +: 2]));
          widx_d  = '0;
          lane_d  = '0;
          have_d  = 1'b0;
          if (total_d == '0) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (!have_q) begin
          if (!wf_empty) begin
            wf_pop = 1'b1;
            cur_d  = wf_data;
            have_d = 1'b1;
            lane_d = '0;
          end
        end else begin
          if (pay) begin
            bv_d     = 1'b1;
            bd_d     = cur_q[lane_q*8 +: 8];
            bf_d     = pstart_q;
            bl_d     = cmda_q[LAST_BIT] && (gidx == g_end - 1'b1);
            pstart_d = 1'b0;
          end
          lane_d = lane_q + 1'b1;
          if (lane_q == 2'd3) begin
            have_d = 1'b0;
            widx_d = widx_q + 1'b1;
            if (widx_q + 1'b1 == total_q) begin
              fin     = 1'b1;
              state_d = ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    st_push = fin && cmda_q[LAST_BIT];
    ioc_d   = fin && cmda_q[IOC_BIT];
  end

  assign st_tag     = (state_q == ST_CMDB) ? wf_data[31:16] : tag_q;
  assign byte_vld   = bv_q;
  assign byte_dat   = bd_q;
  assign byte_first = bf_q;
  assign byte_last  = bl_q;
  assign ioc_pulse  = ioc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmda_q   <= '0;
      tag_q    <= '0;
      total_q  <= '0;
      widx_q   <= '0;
      lane_q   <= '0;
      have_q   <= 1'b0;
      cur_q    <= '0;
      pstart_q <= 1'b0;
      bv_q     <= 1'b0;
      bd_q     <= '0;
      bf_q     <= 1'b0;
      bl_q     <= 1'b0;
      ioc_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmda_q   <= cmda_d;
      tag_q    <= tag_d;
      total_q  <= total_d;
      widx_q   <= widx_d;
      lane_q   <= lane_d;
      have_q   <= have_d;
      cur_q    <= cur_d;
      pstart_q <= pstart_d;
      bv_q     <= bv_d;
      bd_q     <= bd_d;
      bf_q     <= bf_d;
      bl_q     <= bl_d;
      ioc_q    <= ioc_d;
    end
  end
endmodule

// File: rtl/txp_top.sv
module txp_top #(
  parameter int WF_DEPTH = 16,
  parameter int ST_DEPTH = 512,
  parameter int WCNT_W   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  input  logic        stat_pop,
  output logic        byte_vld,
  output logic [7:0]  byte_dat,
  output logic        byte_first,
  output logic        byte_last,
  output logic [31:0] stat_data,
  output logic [9:0]  stat_count,
  output logic        ioc_pulse,
  output logic        stat_full_pulse,
  output logic        overrun_pulse
);
  localparam int SCW = $clog2(ST_DEPTH + 1);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        wf_empty, wf_full, wf_pop;
  logic [31:0] wf_data;
  logic        st_push;
  logic [15:0] st_tag, head_tag;
  logic [SCW-1:0] st_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  txp_word_fifo #(.DEPTH(WF_DEPTH), .WIDTH(32)) u_wfifo (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_valid), .wr_data(wr_data),
    .rd_en(wf_pop), .rd_data(wf_data),
    .empty(wf_empty), .full(wf_full), .ovr_pulse(overrun_pulse)
  );

  txp_parser #(.WCNT_W(WCNT_W)) u_parse (
    .clk(clk), .rst_n(rst_int_n),
    .wf_empty(wf_empty), .wf_data(wf_data), .wf_pop(wf_pop),
    .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_first(byte_first), .byte_last(byte_last),
    .st_push(st_push), .st_tag(st_tag), .ioc_pulse(ioc_pulse)
  );

  txp_stat_fifo #(.DEPTH(ST_DEPTH), .TAG_W(16)) u_sfifo (
    .clk(clk), .rst_n(rst_int_n),
    .push(st_push), .tag(st_tag), .pop(stat_pop),
    .head_tag(head_tag), .count(st_cnt), .full_pulse(stat_full_pulse)
  );

  assign stat_data  = {head_tag, 16'h0000};
  assign stat_count = 10'(st_cnt);
endmodule

// File: rtl/txp_chk.sv
module txp_chk #(
  parameter int ST_DEPTH = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       byte_first,
  input logic       byte_last,
  input logic [9:0] stat_count,
  input logic       stat_pop,
  input logic       st_push,
  input logic       stat_full_pulse,
  input logic       overrun_pulse,
  input logic       wf_full
);
  // R5
  first_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_first |-> byte_vld);
  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> byte_vld);
  // R8
  stat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_count <= 10'(ST_DEPTH));
  // R8
  full_pulse_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_full_pulse |-> stat_count == 10'(ST_DEPTH));
  // R9
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_pulse |-> $past(wf_full));
  // R10
  empty_pop_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pop && stat_count == 10'd0 && !st_push) |=> stat_count == 10'd0);
  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_push) |=> stat_count <= $past(stat_count));
endmodule

bind txp_top txp_chk #(.ST_DEPTH(ST_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .byte_vld(byte_vld), .byte_first(byte_first), .byte_last(byte_last),
  .stat_count(stat_count), .stat_pop(stat_pop), .st_push(st_push),
  .stat_full_pulse(stat_full_pulse), .overrun_pulse(overrun_pulse),
  .wf_full(wf_full)
);

// File: tb/sim_txp_top.sv
module sim_txp_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic        stat_pop;
  logic        byte_vld, byte_first, byte_last;
  logic [7:0]  byte_dat;
  logic [31:0] stat_data;
  logic [9:0]  stat_count;
  logic        ioc_pulse, stat_full_pulse, overrun_pulse;

  int n_chk, n_fail;
  int cap_n;
  logic [7:0] cap_b [1024];
  logic       cap_f [1024];
  logic       cap_l [1024];
  int ioc_n, full_n, ovr_n;
  int cyc;
  bit done;

  txp_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .stat_pop(stat_pop), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_first(byte_first), .byte_last(byte_last), .stat_data(stat_data),
    .stat_count(stat_count), .ioc_pulse(ioc_pulse),
    .stat_full_pulse(stat_full_pulse), .overrun_pulse(overrun_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld && cap_n < 1024) begin
        cap_b[cap_n] = byte_dat;
        cap_f[cap_n] = byte_first;
        cap_l[cap_n] = byte_last;
        cap_n = cap_n + 1;
      end
      if (ioc_pulse) ioc_n = ioc_n + 1;
      if (stat_full_pulse) full_n = full_n + 1;
      if (overrun_pulse) ovr_n = ovr_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    cap_n = 0; ioc_n = 0; full_n = 0; ovr_n = 0;
  endtask

  task automatic idle(input int n);
    wr_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] w);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk_a(input bit ioc, input int code, input int off,
                                       input bit fst, input bit lst, input int cnt);
    mk_a = {ioc, 5'd0, 2'(code), 3'd0, 5'(off), 2'd0, fst, lst, 1'b0, 11'(cnt)};
  endfunction

  function automatic int nwords(input int cnt, input int off, input int code);
    int w;
    w = (cnt + off + 3) / 4;
    if (code == 1) w = ((w + 3) / 4) * 4;
    if (code == 2) w = ((w + 7) / 8) * 8;
    return w;
  endfunction

  // data byte at global index g of the data area is base+g
  task automatic send_buf(input logic [31:0] a, input logic [15:0] tag, input int base);
    int cnt, off, code, w;
    cnt  = int'(a[10:0]);
    off  = int'(a[20:16]);
    code = int'(a[25:24]);
    w    = nwords(cnt, off, code);
    put(a);
    put({tag, 16'h5A5A});
    for (int k = 0; k < w; k++)
      put({8'(base + 4*k + 3), 8'(base + 4*k + 2), 8'(base + 4*k + 1), 8'(base + 4*k)});
  endtask

  task automatic pop_one();
    stat_pop = 1'b1;
    @(negedge clk);
    stat_pop = 1'b0;
  endtask

  task automatic t_reset();
    check(byte_vld == 1'b0, "R1 byte_vld", 32'(byte_vld), 0);
    check(stat_count == 10'd0, "R1 stat_count", 32'(stat_count), 0);
    check(!ioc_pulse && !stat_full_pulse && !overrun_pulse, "R1 pulses",
          {29'd0, ioc_pulse, stat_full_pulse, overrun_pulse}, 0);
  endtask

  task automatic t_simple();
    bit ok;
    clr_cap();
    send_buf(mk_a(0, 0, 0, 1, 1, 8), 16'h1234, 8'h10);
    idle(80);
    check(cap_n == 8, "R2 byte count", 32'(cap_n), 8);
    ok = 1;
    for (int i = 0; i < 8; i++) if (cap_b[i] != 8'(8'h10 + i)) ok = 0;
    check(ok, "R2 little-endian order", {24'd0, cap_b[1]}, 32'h11);
    ok = cap_f[0];
    for (int i = 1; i < 8; i++) if (cap_f[i]) ok = 0;
    check(ok, "R5 first mark", 32'(cap_f[0]), 1);
    ok = cap_l[7];
    for (int i = 0; i < 7; i++) if (cap_l[i]) ok = 0;
    check(ok, "R5 last mark", 32'(cap_l[7]), 1);
    check(stat_count == 10'd1, "R6 one entry", 32'(stat_count), 1);
    check(stat_data == 32'h1234_0000, "R6 entry value", stat_data, 32'h1234_0000);
    check(ioc_n == 0, "R7 no ioc without request", 32'(ioc_n), 0);
    pop_one();
    check(stat_count == 10'd0, "R6 popped", 32'(stat_count), 0);
  endtask

  task automatic t_offset();
    bit ok;
    clr_cap();
    send_buf(mk_a(0, 0, 9, 1, 1, 6), 16'h0001, 8'h40);
    idle(80);
    check(cap_n == 6, "R3 byte count", 32'(cap_n), 6);
    ok = 1;
    for (int i = 0; i < 6; i++) if (cap_b[i] != 8'(8'h49 + i)) ok = 0;
    check(ok, "R3 offset skipped", {24'd0, cap_b[0]}, 32'h49);
    pop_one();
  endtask

  task automatic t_pad();
    bit ok;
    clr_cap();
    send_buf(mk_a(0, 1, 0, 1, 0, 5), 16'h0, 8'h00);
    send_buf(mk_a(0, 2, 2, 0, 0, 3), 16'h0, 8'h20);
    send_buf(mk_a(0, 0, 0, 0, 1, 4), 16'h0777, 8'h80);
    idle(250);
    check(cap_n == 12, "R4 total bytes", 32'(cap_n), 12);
    ok = 1;
    for (int i = 0; i < 5; i++) if (cap_b[i] != 8'(i)) ok = 0;
    for (int i = 0; i < 3; i++) if (cap_b[5+i] != 8'(8'h22 + i)) ok = 0;
    for (int i = 0; i < 4; i++) if (cap_b[8+i] != 8'(8'h80 + i)) ok = 0;
    check(ok, "R4 padding consumed", {24'd0, cap_b[8]}, 32'h80);
    check(stat_count == 10'd1 && stat_data == 32'h0777_0000, "R4 next command parsed",
          stat_data, 32'h0777_0000);
    pop_one();
  endtask

  task automatic t_multi();
    bit ok;
    clr_cap();
    send_buf(mk_a(0, 0, 0, 1, 0, 4), 16'h1111, 8'h20);
    send_buf(mk_a(1, 0, 0, 0, 0, 4), 16'h2222, 8'h24);
    send_buf(mk_a(0, 0, 0, 0, 1, 3), 16'hBEEF, 8'h28);
    idle(150);
    check(cap_n == 11, "R5 multi byte count", 32'(cap_n), 11);
    ok = 1;
    for (int i = 0; i < 11; i++) begin
      if (cap_f[i] != (i == 0)) ok = 0;
      if (cap_l[i] != (i == 10)) ok = 0;
      if (cap_b[i] != 8'(8'h20 + i)) ok = 0;
    end
    check(ok, "R5 marks across segments", 32'(cap_l[10]), 1);
    check(stat_count == 10'd1, "R6 only last segment stores", 32'(stat_count), 1);
    check(stat_data == 32'hBEEF_0000, "R6 tag of last segment", stat_data, 32'hBEEF_0000);
    check(ioc_n == 1, "R7 one ioc pulse", 32'(ioc_n), 1);
    pop_one();
  endtask

  task automatic t_mask_zero();
    bit ok;
    clr_cap();
    send_buf(mk_a(0, 0, 0, 1, 1, 4) | 32'h0000_4800, 16'h00AA, 8'h60);
    idle(60);
    ok = (cap_n == 4);
    for (int i = 0; i < 4 && ok; i++) if (cap_b[i] != 8'(8'h60 + i)) ok = 0;
    check(ok, "R11 reserved bits ignored", 32'(cap_n), 4);
    pop_one();
    clr_cap();
    send_buf(mk_a(1, 0, 0, 1, 1, 0), 16'h0A0A, 0);
    send_buf(mk_a(0, 0, 0, 1, 1, 2), 16'h0B0B, 8'h70);
    idle(40);
    check(cap_n == 2 && cap_b[0] == 8'h70, "R12 zero-length then next", {24'd0, cap_b[0]}, 32'h70);
    check(stat_count == 10'd2 && stat_data == 32'h0A0A_0000, "R12 zero-length status",
          stat_data, 32'h0A0A_0000);
    check(ioc_n == 1, "R7 ioc on zero-length", 32'(ioc_n), 1);
    pop_one();
    pop_one();
  endtask

  task automatic t_full();
    bit ok;
    clr_cap();
    for (int i = 0; i < 513; i++) begin
      wr_valid = 1'b1;
      wr_data  = mk_a(0, 0, 0, 1, 1, 0);
      @(negedge clk);
      wr_data  = {16'(i), 16'h0};
      @(negedge clk);
    end
    idle(20);
    check(stat_count == 10'd512, "R8 count at limit", 32'(stat_count), 512);
    check(full_n == 1, "R8 full pulse once", 32'(full_n), 1);
    ok = 1;
    for (int i = 0; i < 512; i++) begin
      if (stat_data != {16'(i), 16'h0}) ok = 0;
      pop_one();
    end
    check(ok, "R8 entries in order, extra dropped", 32'(stat_count), 0);
    check(stat_count == 10'd0, "R8 drained", 32'(stat_count), 0);
  endtask

  task automatic t_empty_pop();
    pop_one();
    pop_one();
    check(stat_count == 10'd0, "R10 pop on empty", 32'(stat_count), 0);
  endtask

  task automatic t_overrun();
    bit ok;
    int d;
    clr_cap();
    put(mk_a(0, 0, 0, 1, 1, 160));
    put(32'h3333_0000);
    wr_valid = 1'b1;
    for (int k = 0; k < 40; k++) begin
      wr_data = {8'(4*k + 3), 8'(4*k + 2), 8'(4*k + 1), 8'(4*k)};
      @(negedge clk);
    end
    wr_valid = 1'b0;
    idle(300);
    d = ovr_n;
    check(d > 0, "R9 overrun reported", 32'(d), 1);
    for (int k = 0; k < d; k++) put(32'h0);
    idle(300);
    check(cap_n == 160, "R9 buffer completes after refill", 32'(cap_n), 160);
    ok = 1;
    for (int i = 0; i < 56; i++) if (cap_b[i] != 8'(i)) ok = 0;
    check(ok, "R9 accepted words intact", {24'd0, cap_b[55]}, 32'd55);
    check(stat_count == 10'd1, "R9 status after overrun", 32'(stat_count), 1);
    pop_one();
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 0;
    cap_n = 0; ioc_n = 0; full_n = 0; ovr_n = 0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; stat_pop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_simple();
    t_offset();
    t_pad();
    t_multi();
    t_mask_zero();
    t_empty_pop();
    t_full();
    t_overrun();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule